// File: doc/BRIEF.md
# Nine-Bit Serial Display Slave Receiver

This block is the slave side of a three-wire serial link into a display controller. The host clocks nine-bit words in on a serial clock while holding an active-low select. The first bit of each word tells whether the eight bits after it are a command or display data. Each completed word is handed to the controller as a byte, a command/data flag and a one-cycle valid strobe.

One command pattern asks for a read-back. After such a request the host supplies eight more clock pulses. During those pulses the block drives either an identification byte or a status byte on a separate serial output. Once the read is over, it turns that output driver off again.

The serial inputs are brought into the block's clock domain through a parameterised synchroniser. All serial edges are then detected in that domain. Raising the select line, or pulsing the asynchronous reset, abandons any transfer in progress.

Top module: `ser9_slave`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `sdout_oe`, `wr_valid` and `wr_byte` are all 0.
- R2: A word is nine `sdin` bits sampled on rising `sclk` edges. The first bit goes to `wr_is_data` (0 = command, 1 = data). The next eight bits form `wr_byte`, first-received bit in bit 7. `wr_valid` pulses for exactly one clock per completed word.
- R3: While `cs_n` stays low, the rising edge after a word's ninth bit is the flag bit of the next word, with no gap bits.
- R4: While `cs_n` is high the receiver is held cleared. A partial word is dropped without a strobe, and the next word after `cs_n` falls is framed from its first bit.
- R5: Asserting `rst_n` low in the middle of a word aborts it. No strobe is produced, `wr_byte` reads 0, and reception works normally after release.
- R6: `sdout_oe` stays 0 while idle and throughout every write word.
- R7: A read request is a command word (flag 0) whose byte has bit 7 = 1, bit 6 = 0 and bit 0 = 1; the other bits are don't-care. The request is still delivered on the write port. `sdout_oe` rises on the falling `sclk` edge that follows it. A command without that pattern leaves `sdout_oe` at 0.
- R8: During a read, `sdout` carries `id_byte` when `rd_sel` = 0 and `status_byte` when `rd_sel` = 1, using the value of `rd_sel` at the enabling fall. Bits go out most significant first and change only on falling `sclk` edges. `sdout_oe` returns to 0 on the fall after the eighth rising edge.
- R9: Rising edges during a read are not decoded and produce no strobe. The word after a completed read is decoded normally.
- R10: Raising `cs_n` during a read forces `sdout_oe` to 0 in the same clock cycle, before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdin | input | 1 | Serial data in |
| rd_sel | input | 1 | Read source: 0 = identification byte, 1 = status byte |
| id_byte | input | 8 | Identification byte returned by a read |
| status_byte | input | 8 | Status byte returned by a read |
| wr_valid | output | 1 | One-clock strobe for a completed word |
| wr_is_data | output | 1 | Flag of the last word (1 = data) |
| wr_byte | output | 8 | Payload byte of the last word |
| sdout | output | 1 | Serial data out (valid while `sdout_oe` is 1) |
| sdout_oe | output | 1 | Output-driver enable for `sdout` |

## Verification
Some rules are checked by the assertions on every clock:
- `wr_valid` never stays high for two clocks.
- The bit counter stays within one word.
- The select line clears both the frame counter and the output driver.
- The driver only switches on at a falling serial edge.
- The output bit holds still between falling edges.
- No strobe appears while the output is driven.

Other behaviour can only be shown by the bench's scenarios:
- Payload bit order and the command/data split.
- Back-to-back framing.
- Recognition of the read pattern.
- Which byte a read returns and its bit sequence.
- Recovery after an abort by select or by reset.

// File: rtl/ser9_pkg.sv
package ser9_pkg;

  localparam int WORD_BITS = 9;
  localparam int BYTE_BITS = WORD_BITS - 1;

  // Read-back pattern: command word, byte bit 7 set, bit 6 clear, bit 0 set.
  function automatic logic is_read_req(input logic is_data, input logic [BYTE_BITS-1:0] b);
    return (!is_data) && b[BYTE_BITS-1] && !b[BYTE_BITS-2] && b[0];
  endfunction

  function automatic logic [BYTE_BITS-1:0] pick_read(input logic sel,
                                                     input logic [BYTE_BITS-1:0] id,
                                                     input logic [BYTE_BITS-1:0] st);
    return sel ? st : id;
  endfunction

endpackage

// File: rtl/ser9_sync.sv
module ser9_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  generate
    if (STAGES == 0) begin : g_pass
      assign dout = din;
    end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
        end else begin
          stg[0] <= din;
          for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
      end
      assign dout = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ser9_rx.sv
module ser9_rx
  import ser9_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_idle,
  input  logic                 rise,
  input  logic                 sdin_s,
  input  logic                 hold,
  output logic                 wr_valid,
  output logic                 wr_is_data,
  output logic [BYTE_BITS-1:0] wr_byte,
  output logic                 rd_req
);

  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic [CNT_W-1:0]     bit_cnt;
  logic [BYTE_BITS-1:0] acc;
  logic                 take_bit;
  logic                 word_done;
  logic [BYTE_BITS-1:0] next_byte;

  assign take_bit  = rise && !hold && !cs_idle;
  assign word_done = take_bit && (bit_cnt == LAST);
  assign next_byte = {acc[BYTE_BITS-2:0], sdin_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      acc        <= '0;
      wr_valid   <= 1'b0;
      wr_is_data <= 1'b0;
      wr_byte    <= '0;
      rd_req     <= 1'b0;
    end else if (cs_idle) begin
      bit_cnt  <= '0;
      acc      <= '0;
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
      if (word_done) begin
        wr_valid   <= 1'b1;
        wr_is_data <= acc[BYTE_BITS-1];
        wr_byte    <= next_byte;
        rd_req     <= is_read_req(acc[BYTE_BITS-1], next_byte);
        bit_cnt    <= '0;
        acc        <= '0;
      end else if (take_bit) begin
        acc     <= next_byte;
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R2: counter never runs past the last bit of a word
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST) else $error("bit counter out of range");

  // R2: strobe lasts a single clock
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid) else $error("strobe longer than one clock");

  // R4: an idle select leaves the frame empty
  p_cs_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (bit_cnt == '0) && !wr_valid) else $error("frame not cleared by select");

endmodule

// File: rtl/ser9_tx.sv
module ser9_tx
  import ser9_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_idle,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 start,
  input  logic                 sel,
  input  logic [BYTE_BITS-1:0] id_in,
  input  logic [BYTE_BITS-1:0] st_in,
  output logic                 oe_q,
  output logic                 sd,
  output logic                 busy
);

  localparam int LEFT_W = $clog2(BYTE_BITS + 1);

  logic                 pend;
  logic [BYTE_BITS-1:0] sh;
  logic [LEFT_W-1:0]    left;

  assign sd   = sh[BYTE_BITS-1];
  assign busy = pend || oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      oe_q <= 1'b0;
      sh   <= '0;
      left <= '0;
    end else if (cs_idle) begin
      pend <= 1'b0;
      oe_q <= 1'b0;
      sh   <= '0;
      left <= '0;
    end else begin
      if (start) pend <= 1'b1;
      if (pend && fall) begin
        sh   <= pick_read(sel, id_in, st_in);
        oe_q <= 1'b1;
        left <= LEFT_W'(BYTE_BITS);
        pend <= 1'b0;
      end else if (oe_q) begin
        if (rise && left != '0) left <= left - 1'b1;
        if (fall) begin
          if (left == '0) oe_q <= 1'b0;
          else            sh   <= {sh[BYTE_BITS-2:0], 1'b0};
        end
      end
    end
  end

  // R8: driver switches on only at a falling serial edge
  p_oe_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(fall)) else $error("driver enabled off a falling edge");

  // R8: output bit holds between falling edges
  p_bit_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && $past(oe_q) && !$past(fall)) |-> $stable(sd)) else $error("output bit moved");

  // R10: idle select turns the driver off
  p_cs_drops_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !oe_q && !pend) else $error("driver survived select release");

endmodule

// File: rtl/ser9_slave.sv
module ser9_slave
  import ser9_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 sdin,
  input  logic                 rd_sel,
  input  logic [BYTE_BITS-1:0] id_byte,
  input  logic [BYTE_BITS-1:0] status_byte,
  output logic                 wr_valid,
  output logic                 wr_is_data,
  output logic [BYTE_BITS-1:0] wr_byte,
  output logic                 sdout,
  output logic                 sdout_oe
);

  logic [2:0] syn;
  logic       cs_idle, sclk_s, sdin_s, sclk_d;
  logic       rise_ev, fall_ev;
  logic       rd_req, tx_busy, oe_q, sd;

  ser9_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({cs_n, sclk, sdin}), .dout(syn));

  assign cs_idle = syn[2];
  assign sclk_s  = syn[1];
  assign sdin_s  = syn[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign rise_ev = sclk_s && !sclk_d;
  assign fall_ev = !sclk_s && sclk_d;

  ser9_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .rise(rise_ev), .sdin_s(sdin_s),
    .hold(tx_busy), .wr_valid(wr_valid), .wr_is_data(wr_is_data),
    .wr_byte(wr_byte), .rd_req(rd_req));

  ser9_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .rise(rise_ev), .fall(fall_ev),
    .start(rd_req), .sel(rd_sel), .id_in(id_byte), .st_in(status_byte),
    .oe_q(oe_q), .sd(sd), .busy(tx_busy));

  // Raw select gates the driver so release takes effect without waiting for sync.
  assign sdout_oe = oe_q && !cs_n;
  assign sdout    = sdout_oe ? sd : 1'b0;

  // R9: no write strobe while the read driver is on
  p_no_strobe_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> !wr_valid) else $error("strobe during read");

  // R7: a read request is always a command word
  p_req_is_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> wr_valid && !wr_is_data) else $error("read request on a data word");

endmodule

// File: tb/sim_ser9_slave.sv
module sim_ser9_slave;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdin = 1'b0;
  logic       rd_sel = 1'b0;
  logic [7:0] id_byte = 8'h00;
  logic [7:0] status_byte = 8'h00;
  logic       wr_valid, wr_is_data, sdout, sdout_oe;
  logic [7:0] wr_byte;

  int checks = 0;
  int failures = 0;
  int n_strobe = 0;
  int oe_bad = 0;
  logic last_f = 1'b0;
  logic [7:0] last_b = 8'h00;
  logic in_read = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  ser9_slave u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .rd_sel(rd_sel), .id_byte(id_byte), .status_byte(status_byte),
    .wr_valid(wr_valid), .wr_is_data(wr_is_data), .wr_byte(wr_byte),
    .sdout(sdout), .sdout_oe(sdout_oe));

  always @(negedge clk) begin
    if (wr_valid) begin
      n_strobe++;
      last_f = wr_is_data;
      last_b = wr_byte;
    end
    if (sdout_oe && !in_read) oe_bad++;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdin = b; wait_clk(6);
    sclk = 1'b1; wait_clk(8);
    sclk = 1'b0; wait_clk(6);
  endtask

  task automatic send_word(input logic f, input logic [7:0] b);
    send_bit(f);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  // Expected read byte, written without the design's helper
  function automatic logic [7:0] exp_read(input logic s, input logic [7:0] a, input logic [7:0] b);
    if (s == 1'b0) return a;
    return b;
  endfunction

  task automatic do_read(input logic [7:0] exp, input string tag);
    int n0;
    n0 = n_strobe;
    for (int i = 7; i >= 0; i--) begin
      chk(sdout_oe == 1'b1 && sdout == exp[i], tag, {sdout_oe, sdout}, {1'b1, exp[i]});
      sdin = ~sdin; wait_clk(6);
      sclk = 1'b1; wait_clk(8);
      sclk = 1'b0; wait_clk(6);
    end
    chk(sdout_oe == 1'b0, "R8 driver off after 8 pulses", sdout_oe, 0);
    chk(n_strobe == n0, "R9 no strobe during read", n_strobe - n0, 0);
  endtask

  // Flag in bit 8, payload in bits 7:0; none matches the read pattern
  localparam logic [8:0] VEC [8] = '{
    9'h1A5, 9'h03C, 9'h100, 9'h1FF, 9'h0C1, 9'h080, 9'h181, 9'h05A };

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    // R1 reset state
    chk(sdout_oe == 1'b0, "R1 oe after reset", sdout_oe, 0);
    chk(wr_valid == 1'b0, "R1 valid after reset", wr_valid, 0);
    chk(wr_byte == 8'h00, "R1 byte after reset", wr_byte, 0);

    cs_n = 1'b0; wait_clk(6);
    // R2/R3: table walked back to back with select held low
    foreach (VEC[k]) begin
      int n0;
      n0 = n_strobe;
      send_word(VEC[k][8], VEC[k][7:0]);
      chk(n_strobe == n0 + 1, "R3 one strobe per word", n_strobe - n0, 1);
      chk(last_f == VEC[k][8], "R2 flag", last_f, VEC[k][8]);
      chk(last_b == VEC[k][7:0], "R2 byte", last_b, VEC[k][7:0]);
    end
    // R7 negative: C1 has bit 6 set, so no read followed
    chk(sdout_oe == 1'b0, "R7 non-read command keeps oe low", sdout_oe, 0);

    // R4 partial word dropped by select
    begin
      int n0;
      n0 = n_strobe;
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      cs_n = 1'b1; wait_clk(8);
      cs_n = 1'b0; wait_clk(6);
      chk(n_strobe == n0, "R4 partial word dropped", n_strobe - n0, 0);
      send_word(1'b1, 8'h6E);
      chk(n_strobe == n0 + 1 && last_b == 8'h6E && last_f == 1'b1,
          "R4 fresh framing", last_b, 8'h6E);
    end

    // R5 async reset in mid word
    begin
      int n0;
      n0 = n_strobe;
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      rst_n = 1'b0; wait_clk(3);
      rst_n = 1'b1; wait_clk(6);
      chk(n_strobe == n0, "R5 no strobe on abort", n_strobe - n0, 0);
      chk(wr_byte == 8'h00, "R5 byte cleared", wr_byte, 0);
      send_word(1'b0, 8'h24);
      chk(n_strobe == n0 + 1 && last_b == 8'h24 && last_f == 1'b0,
          "R5 reception after reset", last_b, 8'h24);
    end

    // R7/R8 read identification byte
    id_byte = 8'hB4; status_byte = 8'h2D; rd_sel = 1'b0;
    begin
      int n0;
      n0 = n_strobe;
      in_read = 1'b1;
      send_word(1'b0, 8'h81);
      chk(n_strobe == n0 + 1 && last_b == 8'h81 && last_f == 1'b0,
          "R7 request delivered as command", last_b, 8'h81);
      do_read(exp_read(1'b0, id_byte, status_byte), "R8 id bit");
      in_read = 1'b0;
      // R9 next word decoded normally
      send_word(1'b1, 8'h33);
      chk(n_strobe == n0 + 2 && last_b == 8'h33 && last_f == 1'b1,
          "R9 word after read", last_b, 8'h33);
    end

    // R8 read status byte with a different request pattern
    rd_sel = 1'b1;
    in_read = 1'b1;
    send_word(1'b0, 8'hBD);
    do_read(exp_read(1'b1, id_byte, status_byte), "R8 status bit");
    in_read = 1'b0;

    // R10 select raised during a read
    rd_sel = 1'b0;
    in_read = 1'b1;
    send_word(1'b0, 8'h99);
    chk(sdout_oe == 1'b1, "R7 oe after request", sdout_oe, 1);
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b1; wait_clk(8);
      sclk = 1'b0; wait_clk(6);
    end
    cs_n = 1'b1;
    #1;
    chk(sdout_oe == 1'b0, "R10 immediate release", sdout_oe, 1'b0);
    wait_clk(8);
    in_read = 1'b0;
    cs_n = 1'b0; wait_clk(6);
    begin
      int n0;
      n0 = n_strobe;
      send_word(1'b1, 8'hE7);
      chk(n_strobe == n0 + 1 && last_b == 8'hE7, "R10 recovery after abort", last_b, 8'hE7);
    end

    chk(oe_bad == 0, "R6 oe low during writes", oe_bad, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule